// File: doc/BRIEF.md
# Card Command and Response Sequencer

This block sits between a host register interface and a memory-card command engine. The host uses one shared write port to program the following items:
- a 6-bit command index;
- a 32-bit argument, written as two 16-bit halves;
- a command configuration word;
- a clock start/stop control.

From these writes and from a clock-enable state held in the status word, the sequencer decides when a command goes out. A command leaves when a configuration write arrives while the clock runs. A command also leaves when the clock is started while a request is still pending.

After a command is issued, the card side returns a stream of response bytes, closed by a done strobe. The sequencer packs the bytes in pairs into a nine-entry, 16-bit response FIFO, which the host drains one entry per read pulse. The sequencer checks the number of bytes received against the response type in the configuration. A short response sets a timeout flag. A good one sets an end-of-command flag and, when the configuration asks for data, emits a data-phase start pulse with the transfer direction.

Top module: `cmd_seq`

## Requirements
- R1: The command index keeps the low 6 bits of a write on select 0; `cmd_rdback` returns it with bit 6 forced to 1 and bit 7 at 0.
- R2: A write on select 1 replaces only argument bits 31:16, and a write on select 2 replaces only bits 15:0. The argument is visible on `arg_rdback` and `cmd_arg`.
- R3: A configuration write (select 3) stores the data under mask 0x3DFF, clears `active` and marks a request pending.
- R4: A configuration write with bit 10 (stop-transfer) clear reduces the status to its clock-enable bit 8. If bit 8 is set, the command is issued at once: `cmd_issue` pulses one cycle later and `active` rises.
- R5: A clock write (select 4) handles bits 1 and 0 as follows. Data bit 1 sets status bit 8 and issues a pending request when the stored stop-transfer bit is clear. Data bit 0 clears status bit 8, clears `active` and abandons any response in progress. When both bits are set, the stop action wins.
- R6: The configuration bits 1:0 give the response type. Type 0 needs no bytes, types 1 and 3 need at least 4 bytes, and type 2 needs at least 16. The byte presented with the done strobe counts. With too few bytes, status bit 1 (timeout) is set and `active` clears.
- R7: Response byte k is stored in entry k/2: even k in bits 7:0, odd k in bits 15:8. Bytes after the eighteenth are dropped, and all entries are zeroed when a command is issued.
- R8: A good response sets status bit 13 and returns the read pointer to entry 0. With configuration bit 2 set, `data_start` pulses and `data_dir` carries configuration bit 3, with `active` kept high. With bit 2 clear, `active` clears.
- R9: `end_cmd` pulses once for every response that completes, whether it is good or timed out. A response abandoned by a clock stop gives no pulse.
- R10: `rsp_rdata` shows the entry at the read pointer. Each `rsp_rd` pulse advances the pointer, and once nine entries have been read, `rsp_rdata` is zero.
- R11: A configuration write with bit 10 set issues nothing and leaves the status unchanged. A later clock start also issues nothing while that bit stays stored.
- R12: After reset the status, `active`, all pulses, the configuration and the response data are zero, and `cmd_rdback` reads 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_we | input | 1 | Host write strobe |
| hw_sel | input | 3 | Write target: 0 index, 1 argument high, 2 argument low, 3 configuration, 4 clock control |
| hw_wdata | input | 16 | Host write data |
| cmd_rdback | output | 8 | Command index readback with bit 6 set |
| arg_rdback | output | 32 | Argument readback |
| cfg_rdback | output | 14 | Stored configuration |
| status | output | 16 | Status word: bit 1 timeout, bit 8 clock on, bit 13 end of command |
| rsp_rd | input | 1 | Host response read pulse |
| rsp_rdata | output | 16 | Response entry at the read pointer |
| card_rsp_valid | input | 1 | Response byte valid from card side |
| card_rsp_byte | input | 8 | Response byte |
| card_rsp_done | input | 1 | End of response stream |
| cmd_issue | output | 1 | One-cycle command issue pulse |
| cmd_index | output | 6 | Command index to the card side |
| cmd_arg | output | 32 | Argument to the card side |
| end_cmd | output | 1 | One-cycle end-of-command event |
| active | output | 1 | Command or data phase in progress |
| data_start | output | 1 | One-cycle data-phase start pulse |
| data_dir | output | 1 | Data direction, 1 = write to card |

## Verification
The hardest state to reach is a command that is abandoned while its response is still arriving, followed by a request that is pending while the clock is off. The stimulus issues a command, stops the clock before the done strobe and then sends the strobe anyway, so a missing event can be checked. It then writes a configuration with the clock off and sends a combined start-and-stop write before a plain start. Zeroing of stale entries is checked with the ordering of the vector table, where a short response follows a full eighteen-byte one.

// File: rtl/cmd_seq_pkg.sv
// Shared encodings for the command sequencer: host write selects, the
// configuration and status bit positions, and the sequencer state.
package cmd_seq_pkg;
    typedef enum logic [2:0] {
        SEL_INDEX = 3'd0,
        SEL_ARG_HI = 3'd1,
        SEL_ARG_LO = 3'd2,
        SEL_CONFIG = 3'd3,
        SEL_CLOCK  = 3'd4
    } host_sel_e;

    localparam int CFG_W = 14;
    localparam logic [CFG_W-1:0] CFG_KEEP = 14'h3DFF;
    localparam int CB_DATA = 2;
    localparam int CB_DIR  = 3;
    localparam int CB_STOP = 10;

    localparam int STAT_W  = 16;
    localparam int SB_TOUT = 1;
    localparam int SB_CLK  = 8;
    localparam int SB_ENDC = 13;

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_state_e;
endpackage

// File: rtl/cmd_seq_regs.sv
// Command register file: holds the command index, the argument assembled
// from two halves and the masked configuration word.
// Assumes one host write per cycle on the shared select/data port.
module cmd_seq_regs
    import cmd_seq_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_we,
    input  logic [2:0]         hw_sel,
    input  logic [ARG_W/2-1:0] hw_wdata,
    output logic [IDX_W-1:0]   idx_q,
    output logic [ARG_W-1:0]   arg_q,
    output logic [CFG_W-1:0]   cfg_q
);
    localparam int HALF = ARG_W / 2;

    // Capture host writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            arg_q <= '0;
            cfg_q <= '0;
        end else if (hw_we) begin
            case (hw_sel)
                SEL_INDEX:  idx_q <= hw_wdata[IDX_W-1:0];
                SEL_ARG_HI: arg_q[ARG_W-1:HALF] <= hw_wdata;
                SEL_ARG_LO: arg_q[HALF-1:0] <= hw_wdata;
                SEL_CONFIG: cfg_q <= hw_wdata[CFG_W-1:0] & CFG_KEEP;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cmd_seq_ctrl.sv
// Issue and completion control: owns the status word, the pending and
// active flags, the response byte counter and the issue/end/data pulses.
// Assumes the card delivers response bytes only after a cmd_issue pulse.
module cmd_seq_ctrl
    import cmd_seq_pkg::*;
#(
    parameter int BYTES     = 18,
    parameter int SHORT_RSP = 4,
    parameter int LONG_RSP  = 16,
    localparam int CNT_W    = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_wr_stop,
    input  logic              clk_wr,
    input  logic              clk_on_bit,
    input  logic              clk_off_bit,
    input  logic [1:0]        cfg_type,
    input  logic              cfg_data,
    input  logic              cfg_dir,
    input  logic              cfg_stop,
    input  logic              rsp_valid,
    input  logic              rsp_done,
    output logic              issue_now,
    output logic              capture_en,
    output logic              good_now,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [STAT_W-1:0] status_q,
    output logic              active_q,
    output logic              issue_q,
    output logic              end_q,
    output logic              dstart_q,
    output logic              ddir_q
);
    localparam logic [STAT_W-1:0] CLK_ONLY = STAT_W'(1) << SB_CLK;

    seq_state_e        state_q;
    logic              pend_q;
    logic              stop_req, start_req, cfg_issue, clk_issue, rsp_fin, len_ok;
    logic [CNT_W:0]    cnt_eff, need_len;

    // Decode the host actions of this cycle; stop wins over start.
    always_comb begin
        stop_req  = clk_wr && clk_off_bit;
        start_req = clk_wr && clk_on_bit && !clk_off_bit;
        cfg_issue = cfg_wr && !cfg_wr_stop && status_q[SB_CLK];
        clk_issue = start_req && pend_q && !cfg_stop;
        issue_now = cfg_issue || clk_issue;
    end

    // Required byte count per response type and the completion verdict.
    always_comb begin
        case (cfg_type)
            2'd0:    need_len = '0;
            2'd2:    need_len = (CNT_W+1)'(LONG_RSP);
            default: need_len = (CNT_W+1)'(SHORT_RSP);
        endcase
        cnt_eff    = {1'b0, byte_cnt} + (CNT_W+1)'(rsp_valid);
        capture_en = (state_q == ST_WAIT);
        rsp_fin    = capture_en && rsp_done && !stop_req && !cfg_wr;
        len_ok     = (cnt_eff >= need_len);
        good_now   = rsp_fin && len_ok;
    end

    // Sequencer state, status bits, flags and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pend_q   <= 1'b0;
            active_q <= 1'b0;
            status_q <= '0;
            byte_cnt <= '0;
            issue_q  <= 1'b0;
            end_q    <= 1'b0;
            dstart_q <= 1'b0;
            ddir_q   <= 1'b0;
        end else begin
            issue_q  <= 1'b0;
            end_q    <= 1'b0;
            dstart_q <= 1'b0;
            if (stop_req) begin
                status_q[SB_CLK] <= 1'b0;
                active_q <= 1'b0;
                state_q  <= ST_IDLE;
            end else if (start_req) begin
                if (clk_issue) status_q <= CLK_ONLY;
                else           status_q[SB_CLK] <= 1'b1;
            end
            if (cfg_wr) begin
                pend_q   <= 1'b1;
                active_q <= 1'b0;
                state_q  <= ST_IDLE;
                if (!cfg_wr_stop) status_q <= status_q & CLK_ONLY;
            end
            if (issue_now) begin
                pend_q   <= 1'b0;
                active_q <= 1'b1;
                state_q  <= ST_WAIT;
                byte_cnt <= '0;
                issue_q  <= 1'b1;
            end else if (rsp_fin) begin
                end_q   <= 1'b1;
                state_q <= ST_IDLE;
                if (len_ok) begin
                    status_q[SB_ENDC] <= 1'b1;
                    if (cfg_data) begin
                        dstart_q <= 1'b1;
                        ddir_q   <= cfg_dir;
                    end else begin
                        active_q <= 1'b0;
                    end
                end else begin
                    status_q[SB_TOUT] <= 1'b1;
                    active_q <= 1'b0;
                end
            end else if (capture_en && rsp_valid && byte_cnt < CNT_W'(BYTES)) begin
                byte_cnt <= byte_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_seq_rspfifo.sv
// Response store: packs card bytes in pairs into DEPTH 16-bit entries and
// serves them to the host through a read pointer that stops at DEPTH.
// Assumes wr_pos counts bytes from zero since the last clear.
module cmd_seq_rspfifo #(
    parameter int DEPTH   = 9,
    localparam int BYTES  = 2 * DEPTH,
    localparam int CNT_W  = $clog2(BYTES + 1),
    localparam int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_pos,
    input  logic [7:0]       wr_byte,
    input  logic             rd_rst,
    input  logic             rd_en,
    output logic [15:0]      rdata
);
    logic [15:0]      mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        localparam logic [CNT_W-1:0] LO_POS = CNT_W'(2 * e);
        localparam logic [CNT_W-1:0] HI_POS = CNT_W'(2 * e + 1);
        // Zero on issue, otherwise take the byte whose position maps here.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                mem[e] <= '0;
            end else if (wr_en && wr_pos == LO_POS) begin
                mem[e][7:0] <= wr_byte;
            end else if (wr_en && wr_pos == HI_POS) begin
                mem[e][15:8] <= wr_byte;
            end
        end
    end

    // Host read pointer: restart on a good response, saturate at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_rst) begin
            rd_ptr <= '0;
        end else if (rd_en && rd_ptr < PTR_W'(DEPTH)) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Present the entry at the pointer, zero once all have been read.
    always_comb begin
        rdata = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (rd_ptr == PTR_W'(e)) rdata = mem[e];
        end
    end
endmodule

// File: rtl/cmd_seq.sv
// Top of the card command sequencer: decodes host writes, ties the
// register file, the issue controller and the response store together.
// Assumes a single host write per cycle and a card that answers each issue.
module cmd_seq
    import cmd_seq_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int ARG_W     = 32,
    parameter int DEPTH     = 9,
    parameter int SHORT_RSP = 4,
    parameter int LONG_RSP  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_we,
    input  logic [2:0]         hw_sel,
    input  logic [ARG_W/2-1:0] hw_wdata,
    output logic [IDX_W+1:0]   cmd_rdback,
    output logic [ARG_W-1:0]   arg_rdback,
    output logic [CFG_W-1:0]   cfg_rdback,
    output logic [STAT_W-1:0]  status,
    input  logic               rsp_rd,
    output logic [15:0]        rsp_rdata,
    input  logic               card_rsp_valid,
    input  logic [7:0]         card_rsp_byte,
    input  logic               card_rsp_done,
    output logic               cmd_issue,
    output logic [IDX_W-1:0]   cmd_index,
    output logic [ARG_W-1:0]   cmd_arg,
    output logic               end_cmd,
    output logic               active,
    output logic               data_start,
    output logic               data_dir
);
    localparam int BYTES = 2 * DEPTH;
    localparam int CNT_W = $clog2(BYTES + 1);

    logic [IDX_W-1:0] idx_q;
    logic [ARG_W-1:0] arg_q;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_wr, clk_wr, issue_now, capture_en, good_now;
    logic [CNT_W-1:0] byte_cnt;

    // Write-target decode for the two actions the controller sees.
    always_comb begin
        cfg_wr = hw_we && (hw_sel == SEL_CONFIG);
        clk_wr = hw_we && (hw_sel == SEL_CLOCK);
    end

    cmd_seq_regs #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_we    (hw_we),
        .hw_sel   (hw_sel),
        .hw_wdata (hw_wdata),
        .idx_q    (idx_q),
        .arg_q    (arg_q),
        .cfg_q    (cfg_q)
    );

    cmd_seq_ctrl #(.BYTES(BYTES), .SHORT_RSP(SHORT_RSP), .LONG_RSP(LONG_RSP)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wr_stop (hw_wdata[CB_STOP]),
        .clk_wr      (clk_wr),
        .clk_on_bit  (hw_wdata[1]),
        .clk_off_bit (hw_wdata[0]),
        .cfg_type    (cfg_q[1:0]),
        .cfg_data    (cfg_q[CB_DATA]),
        .cfg_dir     (cfg_q[CB_DIR]),
        .cfg_stop    (cfg_q[CB_STOP]),
        .rsp_valid   (card_rsp_valid),
        .rsp_done    (card_rsp_done),
        .issue_now   (issue_now),
        .capture_en  (capture_en),
        .good_now    (good_now),
        .byte_cnt    (byte_cnt),
        .status_q    (status),
        .active_q    (active),
        .issue_q     (cmd_issue),
        .end_q       (end_cmd),
        .dstart_q    (data_start),
        .ddir_q      (data_dir)
    );

    cmd_seq_rspfifo #(.DEPTH(DEPTH)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (issue_now),
        .wr_en   (capture_en && card_rsp_valid && !issue_now),
        .wr_pos  (byte_cnt),
        .wr_byte (card_rsp_byte),
        .rd_rst  (good_now),
        .rd_en   (rsp_rd),
        .rdata   (rsp_rdata)
    );

    // Readback views and the command handed to the card side.
    always_comb begin
        cmd_rdback = {1'b0, 1'b1, idx_q};
        arg_rdback = arg_q;
        cfg_rdback = cfg_q;
        cmd_index  = idx_q;
        cmd_arg    = arg_q;
    end
endmodule

// File: rtl/cmd_seq_chk.sv
// Protocol checker for cmd_seq, attached by bind below.
module cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_wr,
    input logic hold_cfg_wr,
    input logic card_rsp_done,
    input logic clk_bit,
    input logic tout_bit,
    input logic endc_bit,
    input logic active,
    input logic cmd_issue,
    input logic end_cmd,
    input logic data_start
);
    // R5
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!clk_bit && !active));
    // R11
    hold_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cfg_wr |=> (!cmd_issue && !active));
    // R4
    issue_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> active);
    // R9
    end_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_cmd |-> $past(card_rsp_done));
    // R6
    tout_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_bit) |-> $past(card_rsp_done));
    // R8
    start_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |-> (active && endc_bit));
endmodule

bind cmd_seq cmd_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_wr       (hw_we && hw_sel == 3'd4 && hw_wdata[0]),
    .hold_cfg_wr   (hw_we && hw_sel == 3'd3 && hw_wdata[10]),
    .card_rsp_done (card_rsp_done),
    .clk_bit       (status[8]),
    .tout_bit      (status[1]),
    .endc_bit      (status[13]),
    .active        (active),
    .cmd_issue     (cmd_issue),
    .end_cmd       (end_cmd),
    .data_start    (data_start)
);

// File: tb/cmd_seq_bench.sv
module cmd_seq_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0] rtype;
        logic       den;
        logic       dir;
        logic [4:0] nb;
        logic       tout;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd1, 1'b0, 1'b0, 5'd4,  1'b0},
        '{2'd2, 1'b0, 1'b0, 5'd18, 1'b0},
        '{2'd1, 1'b0, 1'b0, 5'd3,  1'b1},
        '{2'd3, 1'b1, 1'b1, 5'd4,  1'b0},
        '{2'd2, 1'b0, 1'b0, 5'd15, 1'b1},
        '{2'd0, 1'b1, 1'b0, 5'd0,  1'b0},
        '{2'd2, 1'b0, 1'b0, 5'd20, 1'b0},
        '{2'd3, 1'b0, 1'b0, 5'd5,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_we = 1'b0;
    logic [2:0]  hw_sel = '0;
    logic [15:0] hw_wdata = '0;
    logic [7:0]  cmd_rdback;
    logic [31:0] arg_rdback;
    logic [13:0] cfg_rdback;
    logic [15:0] status;
    logic        rsp_rd = 1'b0;
    logic [15:0] rsp_rdata;
    logic        card_rsp_valid = 1'b0;
    logic [7:0]  card_rsp_byte = '0;
    logic        card_rsp_done = 1'b0;
    logic        cmd_issue;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        end_cmd, active, data_start, data_dir;

    int n_checks = 0, n_fail = 0;
    int n_issue = 0, n_end = 0, n_ds = 0;
    logic last_dir = 1'b0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_seq u_cmd_seq (
        .clk(clk), .rst_n(rst_n), .hw_we(hw_we), .hw_sel(hw_sel), .hw_wdata(hw_wdata),
        .cmd_rdback(cmd_rdback), .arg_rdback(arg_rdback), .cfg_rdback(cfg_rdback),
        .status(status), .rsp_rd(rsp_rd), .rsp_rdata(rsp_rdata),
        .card_rsp_valid(card_rsp_valid), .card_rsp_byte(card_rsp_byte),
        .card_rsp_done(card_rsp_done), .cmd_issue(cmd_issue), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .end_cmd(end_cmd), .active(active),
        .data_start(data_start), .data_dir(data_dir)
    );

    // Count one-cycle pulses, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_issue) n_issue++;
            if (end_cmd) n_end++;
            if (data_start) begin
                n_ds++;
                last_dir = data_dir;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic host_wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        hw_we = 1'b1; hw_sel = sel; hw_wdata = data;
        @(negedge clk);
        hw_we = 1'b0;
        #1;
    endtask

    function automatic logic [7:0] bval(input int v, input int i);
        return 8'(v * 32 + i + 5);
    endfunction

    task automatic card_reply(input int v, input int nb);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            card_rsp_valid = 1'b1; card_rsp_byte = bval(v, i);
        end
        @(negedge clk);
        card_rsp_valid = 1'b0; card_rsp_done = 1'b1;
        @(negedge clk);
        card_rsp_done = 1'b0;
        settle();
    endtask

    task automatic host_rd(output logic [15:0] val);
        @(negedge clk);
        val = rsp_rdata;
        rsp_rd = 1'b1;
        @(negedge clk);
        rsp_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int bi, be;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R12 reset state
        chk(status == 16'h0, "R12", "status", status, 0);
        chk(!active && !cmd_issue && !end_cmd && !data_start, "R12", "flags", active, 0);
        chk(cmd_rdback == 8'h40, "R12", "cmd_rdback", cmd_rdback, 8'h40);
        chk(rsp_rdata == 16'h0 && cfg_rdback == 14'h0, "R12", "rsp/cfg", rsp_rdata, 0);

        // R1 index width and forced bit
        host_wr(3'd0, 16'hFFFF);
        chk(cmd_rdback == 8'h7F && cmd_index == 6'h3F, "R1", "cmd_rdback", cmd_rdback, 8'h7F);
        host_wr(3'd0, 16'h0011);
        chk(cmd_rdback == 8'h51, "R1", "cmd_rdback", cmd_rdback, 8'h51);
        // R2 argument halves
        host_wr(3'd1, 16'hABCD);
        host_wr(3'd2, 16'h1234);
        chk(arg_rdback == 32'hABCD1234, "R2", "arg", arg_rdback, 32'hABCD1234);
        host_wr(3'd1, 16'h5555);
        chk(arg_rdback == 32'h55551234 && cmd_arg == 32'h55551234, "R2", "arg hi only",
            arg_rdback, 32'h55551234);
        host_wr(3'd2, 16'h0F0F);
        chk(arg_rdback == 32'h55550F0F, "R2", "arg lo only", arg_rdback, 32'h55550F0F);

        // R3 mask; clock off so nothing issues
        host_wr(3'd3, 16'hFFFF);
        chk(cfg_rdback == 14'h3DFF, "R3", "cfg mask", cfg_rdback, 14'h3DFF);
        chk(n_issue == 0 && status == 16'h0, "R11", "no issue clock off", n_issue, 0);
        // R4: pending with clock off, then R5 start issues it
        host_wr(3'd3, 16'h0001);
        settle();
        chk(n_issue == 0 && !active, "R4", "no issue while clock off", n_issue, 0);
        host_wr(3'd4, 16'h0002);
        settle();
        chk(n_issue == 1 && status == 16'h0100 && active, "R5", "start issues pending",
            n_issue, 1);
        card_reply(9, 4);
        chk(status == 16'h2100 && n_end == 1, "R8", "good response status", status, 16'h2100);

        // Vector table: R4 R6 R7 R8 R9 R10
        for (int v = 0; v < 8; v++) begin
            int is0, ie0, ids0;
            logic [15:0] exp_st;
            is0 = n_issue; ie0 = n_end; ids0 = n_ds;
            host_wr(3'd3, {12'h0, VEC[v].dir, VEC[v].den, VEC[v].rtype});
            chk(n_issue == is0 + 1 || cmd_issue, "R4", "issue on config write", n_issue, is0 + 1);
            card_reply(v, int'(VEC[v].nb));
            exp_st = VEC[v].tout ? 16'h0102 : 16'h2100;
            chk(status == exp_st, "R6", $sformatf("status vec%0d", v), status, exp_st);
            chk(n_issue == is0 + 1 && n_end == ie0 + 1, "R9",
                $sformatf("issue/end vec%0d", v), n_end, ie0 + 1);
            chk(active == (!VEC[v].tout && VEC[v].den), "R8",
                $sformatf("active vec%0d", v), active, !VEC[v].tout && VEC[v].den);
            if (!VEC[v].tout && VEC[v].den) begin
                chk(n_ds == ids0 + 1 && last_dir == VEC[v].dir, "R8",
                    $sformatf("data start vec%0d", v), last_dir, VEC[v].dir);
            end else begin
                chk(n_ds == ids0, "R8", $sformatf("no data start vec%0d", v), n_ds, ids0);
            end
            if (!VEC[v].tout) begin
                for (int e = 0; e < 9; e++) begin
                    logic [15:0] exp_e;
                    bi = 2 * e; be = int'(VEC[v].nb);
                    exp_e[7:0]  = (bi < be) ? bval(v, bi) : 8'h00;
                    exp_e[15:8] = (bi + 1 < be) ? bval(v, bi + 1) : 8'h00;
                    host_rd(rd);
                    chk(rd == exp_e, "R7", $sformatf("entry %0d vec%0d", e, v), rd, exp_e);
                end
                if (v == 0) begin
                    host_rd(rd);
                    chk(rd == 16'h0, "R10", "read past nine", rd, 0);
                    host_rd(rd);
                    chk(rd == 16'h0, "R10", "second read past nine", rd, 0);
                end
            end
        end

        // R3: config write clears active during a data phase (vec3 style)
        host_wr(3'd3, 16'h0005);
        card_reply(1, 4);
        chk(active, "R8", "data phase active", active, 1);
        host_wr(3'd3, 16'h0405);
        chk(!active && status == 16'h2100, "R3", "config write clears active", active, 0);

        // R5: clock stop abandons the response
        host_wr(3'd3, 16'h0001);
        begin
            int ie0;
            ie0 = n_end;
            host_wr(3'd4, 16'h0001);
            chk(status == 16'h0 && !active, "R5", "stop clears", status, 0);
            card_reply(2, 4);
            chk(n_end == ie0 && status == 16'h0, "R9", "no end after abort", n_end, ie0);
        end
        // R5: start and stop together, stop wins
        host_wr(3'd3, 16'h0001);
        begin
            int is0;
            is0 = n_issue;
            host_wr(3'd4, 16'h0003);
            settle();
            chk(n_issue == is0 && status == 16'h0, "R5", "stop wins", n_issue, is0);
            host_wr(3'd4, 16'h0002);
            settle();
            chk(n_issue == is0 + 1 && status == 16'h0100 && active, "R5",
                "start after both", n_issue, is0 + 1);
            // R11: stop-transfer config leaves status, issues nothing
            host_wr(3'd3, 16'h0401);
            settle();
            chk(n_issue == is0 + 1 && status == 16'h0100 && !active, "R11",
                "hold config", status, 16'h0100);
            host_wr(3'd4, 16'h0002);
            settle();
            chk(n_issue == is0 + 1, "R11", "start with hold stored", n_issue, is0 + 1);
        end

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule